// File: doc/BRIEF.md
# Banked ROM Word Address Former with Two-Cycle Table Read

This unit drives the single 16-bit word address bus of an external program ROM. Three clients share the bus. The first is the instruction fetch of the processor core. The second is table lookup, also issued by the core. The third is sample fetch by the wavetable engine. Each cycle the unit picks one client and builds that client's address. An instruction fetch uses the bank select followed by the program counter. A table lookup uses the pointer register for the low byte, and the upper bits come either from the running page or from the final page of the bank. A sample fetch uses the wavetable start word, shifted up.

A table read takes two cycles. In the first cycle the table address goes out. In the second cycle that address stays on the bus and the returned word is split into two bytes. The low byte is presented for one cycle to the data-memory side, which always accepts it. The high byte is latched into a register that software can only read. The pointer register is at register address 07H and the high-byte register is at 08H; both sit on a small register port.

Table requests and wavetable requests use valid/ready handshakes. A requester must hold valid and its payload (mode bit or start word) steady until ready is seen high in the same cycle. There is no other back-pressure: the low-byte output and the read-return markers have no ready. The ROM is synchronous: the word for an address driven in one cycle is present on `rom_data_i` in the next cycle.

Top module: `romtbl_unit`

## Requirements
- R1: When `fetch_gnt_o` is high, `rom_addr_o` equals `{bank_i, ctr_i}`. The fetch is granted when `fetch_req_i` is high, no table read is in progress, `tbl_valid_i` is low and no waiting wavetable request takes the cycle.
- R2: A current-page table read (`tbl_last_i`=0) accepted with `tbl_valid_i && tbl_ready_o` drives `rom_addr_o = {bank_i, ctr_i[12:8], ptr}`, where ptr is the 8-bit pointer register.
- R3: A last-page table read (`tbl_last_i`=1) drives `rom_addr_o = {bank_i, 5'b11111, ptr}`.
- R4: A granted wavetable request (`wv_valid_i && wv_ready_o`) drives `rom_addr_o = {wv_start_i, 4'b0000}`.
- R5: In the cycle after a table read is accepted, `rom_addr_o` holds the table address. In that cycle `tbl_ready_o`, `fetch_gnt_o` and `wv_ready_o` are low, and `lo_valid_o` is high with `lo_byte_o` = bits 7:0 of the returned word. In the cycle after that, a pending fetch is granted again.
- R6: At the end of the second table-read cycle, bits 15:8 of the returned word are loaded into the high-byte register. A read at register address 08H returns that register.
- R7: A write with `reg_wr_i` high at register address 07H loads `reg_wdata_i` into the pointer register. A read at 07H returns it.
- R8: A write to register address 08H has no effect. The high-byte register changes only at the end of a table read.
- R9: In a cycle with no table read in progress, the order of priority is: a table request first, then a fetch, then a wavetable request. The one exception is a wavetable request that was valid but not granted in the previous cycle: it wins the cycle.
- R10: After reset, the pointer and high-byte registers read 0 and `lo_valid_o`, `fetch_rvalid_o` and `wv_rvalid_o` are low.
- R11: `fetch_rvalid_o` and `wv_rvalid_o` rise in the cycle after a fetch grant or a wavetable grant respectively. In that cycle the word is on `rom_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bank_i | input | 3 | Bank select |
| ctr_i | input | 13 | Program counter |
| fetch_req_i | input | 1 | Core requests an instruction fetch this cycle |
| fetch_gnt_o | output | 1 | Fetch address is on the bus this cycle |
| fetch_rvalid_o | output | 1 | Fetched word is on `rom_data_i` |
| tbl_valid_i | input | 1 | Table-read request valid |
| tbl_last_i | input | 1 | 1 = last-page mode, 0 = current-page mode |
| tbl_ready_o | output | 1 | Table request accepted when valid is also high |
| lo_valid_o | output | 1 | Low byte of table word is valid |
| lo_byte_o | output | 8 | Low byte bound for data memory |
| wv_valid_i | input | 1 | Wavetable request valid |
| wv_start_i | input | 12 | Wavetable start word |
| wv_ready_o | output | 1 | Wavetable request granted |
| wv_rvalid_o | output | 1 | Wavetable word is on `rom_data_i` |
| rom_addr_o | output | 16 | ROM word address |
| rom_data_i | input | 16 | ROM word returned one cycle after its address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
The bench keeps a fetch request high across a table read. A design that forgot the hold cycle would grant a fetch or move the bus in the second cycle, or would let the fetch win against the table request. It runs both page modes with different bank and counter values. A swapped or unforced upper field shows up as a wrong address and a wrong returned low byte. It writes to the high-byte register address and reads the value back, which catches a register that accepts writes. It holds a wavetable request against a continuous fetch. A design without the one-cycle catch-up would starve the sample fetch, and one that inverted priority would take the fetch's first cycle.

// File: rtl/romtbl_pkg.sv
package romtbl_pkg;
  typedef enum logic [2:0] {
    SRC_IDLE,
    SRC_FETCH,
    SRC_TBL,
    SRC_HOLD,
    SRC_WAVE
  } src_e;
endpackage

// File: rtl/romtbl_addr_form.sv
module romtbl_addr_form
  import romtbl_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int CTR_W  = 13,
  parameter int PTR_W  = 8,
  parameter int WAV_W  = 12,
  parameter int ADDR_W = BANK_W + CTR_W
) (
  input  src_e              src_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              last_i,
  input  logic [WAV_W-1:0]  wav_i,
  input  logic [ADDR_W-1:0] hold_i,
  output logic [ADDR_W-1:0] tbl_a_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAGE_HI_W = CTR_W - PTR_W;
  localparam int WAV_SH    = ADDR_W - WAV_W;

  logic [ADDR_W-1:0] fetch_a, tbl_a, wav_a;

  assign fetch_a = {bank_i, ctr_i};
  assign tbl_a   = {bank_i, (last_i ? {PAGE_HI_W{1'b1}} : ctr_i[CTR_W-1:PTR_W]), ptr_i};
  assign tbl_a_o = tbl_a;

  generate
    if (WAV_SH > 0) begin : g_pad
      assign wav_a = {wav_i, {WAV_SH{1'b0}}};
    end else begin : g_trunc
      assign wav_a = wav_i[WAV_W-1 -: ADDR_W];
    end
  endgenerate

  always_comb begin
    case (src_i)
      SRC_TBL:  addr_o = tbl_a;
      SRC_HOLD: addr_o = hold_i;
      SRC_WAVE: addr_o = wav_a;
      default:  addr_o = fetch_a;
    endcase
  end
endmodule

// File: rtl/romtbl_arb.sv
module romtbl_arb
  import romtbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic tbl_valid_i,
  input  logic fetch_req_i,
  input  logic wv_valid_i,
  output logic tbl_ready_o,
  output logic fetch_gnt_o,
  output logic wv_ready_o,
  output src_e src_o
);
  logic wait_q;
  logic wave_first;

  assign wave_first  = wv_valid_i && wait_q;
  assign tbl_ready_o = !busy_i && !wave_first;
  assign fetch_gnt_o = fetch_req_i && !busy_i && !wave_first && !tbl_valid_i;
  assign wv_ready_o  = !busy_i && (wait_q || (!tbl_valid_i && !fetch_req_i));

  always_comb begin
    if (busy_i)           src_o = SRC_HOLD;
    else if (wave_first)  src_o = SRC_WAVE;
    else if (tbl_valid_i) src_o = SRC_TBL;
    else if (fetch_req_i) src_o = SRC_FETCH;
    else if (wv_valid_i)  src_o = SRC_WAVE;
    else                  src_o = SRC_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wv_valid_i && !wv_ready_o;
  end
endmodule

// File: rtl/romtbl_seq.sv
module romtbl_seq #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] tbl_a_i,
  input  logic [WORD_W-1:0] rom_data_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] hold_o,
  output logic              lo_valid_o,
  output logic [BYTE_W-1:0] lo_byte_o,
  output logic [BYTE_W-1:0] hi_o
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_o <= '0;
      hi_o   <= '0;
    end else begin
      busy_q <= take_i;
      if (take_i) hold_o <= tbl_a_i;
      if (busy_q) hi_o   <= rom_data_i[WORD_W-1:BYTE_W];
    end
  end

  assign busy_o     = busy_q;
  assign lo_valid_o = busy_q;
  assign lo_byte_o  = rom_data_i[BYTE_W-1:0];
endmodule

// File: rtl/romtbl_regs.sv
module romtbl_regs #(
  parameter int            RA_W     = 8,
  parameter int            DAT_W    = 8,
  parameter logic [RA_W-1:0] PTR_ADDR = 8'h07,
  parameter logic [RA_W-1:0] HI_ADDR  = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [RA_W-1:0]  addr_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic [DAT_W-1:0] hi_i,
  output logic [DAT_W-1:0] ptr_o,
  output logic [DAT_W-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                          ptr_o <= '0;
    else if (wr_i && addr_i == PTR_ADDR) ptr_o <= wdata_i;
  end

  always_comb begin
    if (addr_i == PTR_ADDR)     rdata_o = ptr_o;
    else if (addr_i == HI_ADDR) rdata_o = hi_i;
    else                        rdata_o = '0;
  end
endmodule

// File: rtl/romtbl_unit.sv
module romtbl_unit
  import romtbl_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int CTR_W  = 13,
  parameter int WAV_W  = 12,
  parameter int WORD_W = 16,
  parameter int RA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [CTR_W-1:0]      ctr_i,
  input  logic                  fetch_req_i,
  output logic                  fetch_gnt_o,
  output logic                  fetch_rvalid_o,
  input  logic                  tbl_valid_i,
  input  logic                  tbl_last_i,
  output logic                  tbl_ready_o,
  output logic                  lo_valid_o,
  output logic [WORD_W/2-1:0]   lo_byte_o,
  input  logic                  wv_valid_i,
  input  logic [WAV_W-1:0]      wv_start_i,
  output logic                  wv_ready_o,
  output logic                  wv_rvalid_o,
  output logic [BANK_W+CTR_W-1:0] rom_addr_o,
  input  logic [WORD_W-1:0]     rom_data_i,
  input  logic                  reg_wr_i,
  input  logic [RA_W-1:0]       reg_addr_i,
  input  logic [WORD_W/2-1:0]   reg_wdata_i,
  output logic [WORD_W/2-1:0]   reg_rdata_o
);
  localparam int ADDR_W = BANK_W + CTR_W;
  localparam int BYTE_W = WORD_W / 2;

  src_e              src;
  logic              busy, take;
  logic [BYTE_W-1:0] ptr, hi_byte;
  logic [ADDR_W-1:0] tbl_a, hold_a;

  assign take = tbl_valid_i && tbl_ready_o;

  romtbl_arb u_arb (
    .clk(clk), .rst_n(rst_n), .busy_i(busy),
    .tbl_valid_i(tbl_valid_i), .fetch_req_i(fetch_req_i), .wv_valid_i(wv_valid_i),
    .tbl_ready_o(tbl_ready_o), .fetch_gnt_o(fetch_gnt_o), .wv_ready_o(wv_ready_o),
    .src_o(src)
  );

  romtbl_addr_form #(.BANK_W(BANK_W), .CTR_W(CTR_W), .PTR_W(BYTE_W),
                     .WAV_W(WAV_W), .ADDR_W(ADDR_W)) u_form (
    .src_i(src), .bank_i(bank_i), .ctr_i(ctr_i), .ptr_i(ptr),
    .last_i(tbl_last_i), .wav_i(wv_start_i), .hold_i(hold_a),
    .tbl_a_o(tbl_a), .addr_o(rom_addr_o)
  );

  romtbl_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take_i(take), .tbl_a_i(tbl_a),
    .rom_data_i(rom_data_i), .busy_o(busy), .hold_o(hold_a),
    .lo_valid_o(lo_valid_o), .lo_byte_o(lo_byte_o), .hi_o(hi_byte)
  );

  romtbl_regs #(.RA_W(RA_W), .DAT_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .hi_i(hi_byte), .ptr_o(ptr), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_rvalid_o <= 1'b0;
      wv_rvalid_o    <= 1'b0;
    end else begin
      fetch_rvalid_o <= fetch_gnt_o;
      wv_rvalid_o    <= wv_valid_i && wv_ready_o;
    end
  end
endmodule

// File: rtl/romtbl_chk.sv
module romtbl_chk #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bank_i,
  input logic [12:0]   ctr_i,
  input logic          fetch_gnt_o,
  input logic          tbl_valid_i,
  input logic          tbl_ready_o,
  input logic          lo_valid_o,
  input logic          wv_valid_i,
  input logic          wv_ready_o,
  input logic          wv_rvalid_o,
  input logic [AW-1:0] rom_addr_o,
  input logic [WW-1:0] rom_data_i,
  input logic [BW-1:0] hi
);
  a_r1_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_gnt_o |-> rom_addr_o == {bank_i, ctr_i});

  a_r5_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_valid_i && tbl_ready_o) |=>
      (lo_valid_o && !tbl_ready_o && !fetch_gnt_o && !wv_ready_o
       && rom_addr_o == $past(rom_addr_o)));

  a_r5_single_lo: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid_o |=> !lo_valid_o);

  a_r6_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid_o |=> hi == $past(rom_data_i[WW-1:BW]));

  a_r8_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_valid_o |=> $stable(hi));

  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_gnt_o, tbl_valid_i && tbl_ready_o, wv_valid_i && wv_ready_o}));

  a_r9_wave_catchup: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_valid_i && !wv_ready_o && !(tbl_valid_i && tbl_ready_o)) |=>
      (!wv_valid_i || wv_ready_o));

  a_r11_wave_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_valid_i && wv_ready_o) |=> wv_rvalid_o);
endmodule

bind romtbl_unit romtbl_chk #(.AW(BANK_W + CTR_W), .BW(WORD_W / 2), .WW(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_i(bank_i), .ctr_i(ctr_i),
  .fetch_gnt_o(fetch_gnt_o), .tbl_valid_i(tbl_valid_i), .tbl_ready_o(tbl_ready_o),
  .lo_valid_o(lo_valid_o), .wv_valid_i(wv_valid_i), .wv_ready_o(wv_ready_o),
  .wv_rvalid_o(wv_rvalid_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
  .hi(hi_byte)
);

// File: tb/test_romtbl_unit.sv
module test_romtbl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bank_i = '0;
  logic [12:0] ctr_i = '0;
  logic        fetch_req_i = 1'b0, tbl_valid_i = 1'b0, tbl_last_i = 1'b0;
  logic        wv_valid_i = 1'b0;
  logic [11:0] wv_start_i = '0;
  logic [15:0] rom_data_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0, reg_wdata_i = '0;
  logic        fetch_gnt_o, fetch_rvalid_o, tbl_ready_o, lo_valid_o, wv_ready_o, wv_rvalid_o;
  logic [7:0]  lo_byte_o, reg_rdata_o;
  logic [15:0] rom_addr_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0]  lo_q[$];
  logic [15:0] wv_q[$];
  logic [7:0]  exp_hi;

  romtbl_unit i_romtbl_unit (.*);

  always #10 clk = ~clk;

  function automatic logic [15:0] rom_fn(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk) rom_data_i <= rom_fn(rom_addr_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // monitor: pops expected results as the design presents them
  always @(negedge clk) begin
    #2;
    if (rst_n && lo_valid_o) begin
      if (lo_q.size() == 0) check("R5 unexpected lo_valid", 1, 0);
      else check("R5 lo_byte", lo_byte_o, lo_q.pop_front());
    end
    if (rst_n && wv_rvalid_o) begin
      if (wv_q.size() == 0) check("R11 unexpected wv_rvalid", 1, 0);
      else check("R11 wave word", rom_data_i, wv_q.pop_front());
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  // drive one table read of the given mode and check its two cycles
  task automatic table_read(bit last, logic [7:0] ptr);
    logic [15:0] a;
    a = {bank_i, (last ? 5'h1F : ctr_i[12:8]), ptr};
    cyc(); tbl_valid_i = 1; tbl_last_i = last; fetch_req_i = 1; #1;
    check("R9 table before fetch ready", tbl_ready_o, 1);
    check("R9 fetch blocked by table", fetch_gnt_o, 0);
    check(last ? "R3 last-page addr" : "R2 current-page addr", rom_addr_o, a);
    lo_q.push_back(rom_fn(a)[7:0]);
    exp_hi = rom_fn(a)[15:8];
    cyc(); tbl_valid_i = 0; #1;
    check("R5 second cycle no ready", tbl_ready_o, 0);
    check("R5 second cycle no fetch", fetch_gnt_o, 0);
    check("R5 address held", rom_addr_o, a);
    check("R5 lo_valid", lo_valid_o, 1);
    cyc(); reg_addr_i = 8'h08; #1;
    check("R5 fetch resumes", fetch_gnt_o, 1);
    check("R1 fetch addr", rom_addr_o, {bank_i, ctr_i});
    check("R6 high byte", reg_rdata_o, exp_hi);
    fetch_req_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cyc(); rst_n = 1; reg_addr_i = 8'h07; #1;
    check("R10 ptr reset", reg_rdata_o, 0);
    check("R10 lo_valid reset", lo_valid_o, 0);
    check("R10 rvalid reset", {fetch_rvalid_o, wv_rvalid_o}, 0);
    reg_addr_i = 8'h08; #1;
    check("R10 hi reset", reg_rdata_o, 0);

    cyc(); reg_wr_i = 1; reg_addr_i = 8'h07; reg_wdata_i = 8'h3C;
    cyc(); reg_wr_i = 0; #1;
    check("R7 ptr readback", reg_rdata_o, 8'h3C);

    cyc(); bank_i = 3'd5; ctr_i = 13'h1ABC; fetch_req_i = 1; #1;
    check("R1 fetch grant", fetch_gnt_o, 1);
    check("R1 fetch addr", rom_addr_o, 16'hBABC);
    cyc(); fetch_req_i = 0; #1;
    check("R11 fetch_rvalid", fetch_rvalid_o, 1);

    table_read(0, 8'h3C);
    table_read(1, 8'h3C);

    cyc(); reg_wr_i = 1; reg_addr_i = 8'h08; reg_wdata_i = ~exp_hi;
    cyc(); reg_wr_i = 0; #1;
    check("R8 hi write ignored", reg_rdata_o, exp_hi);

    cyc(); reg_wr_i = 1; reg_addr_i = 8'h07; reg_wdata_i = 8'hF0;
    cyc(); reg_wr_i = 0; bank_i = 3'd2; ctr_i = 13'h0007;
    table_read(0, 8'hF0);

    cyc(); wv_valid_i = 1; wv_start_i = 12'hABC; #1;
    check("R4 wave grant", wv_ready_o, 1);
    check("R4 wave addr", rom_addr_o, 16'hABC0);
    wv_q.push_back(rom_fn(16'hABC0));
    cyc(); wv_valid_i = 0;

    cyc(); wv_valid_i = 1; wv_start_i = 12'h123; fetch_req_i = 1; #1;
    check("R9 fetch over wave", fetch_gnt_o, 1);
    check("R9 wave waits", wv_ready_o, 0);
    cyc(); #1;
    check("R9 waited wave wins", wv_ready_o, 1);
    check("R9 fetch yields", fetch_gnt_o, 0);
    check("R4 wave addr", rom_addr_o, 16'h1230);
    wv_q.push_back(rom_fn(16'h1230));
    cyc(); wv_valid_i = 0; #1;
    check("R9 fetch after wave", fetch_gnt_o, 1);
    fetch_req_i = 0;

    repeat (3) cyc();
    check("R5 all lo results seen", lo_q.size(), 0);
    check("R11 all wave results seen", wv_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule